// File: doc/BRIEF.md
# Turf Protection Region Checker

The block checks every memory access against a small table of protection regions. A region is a contiguous byte range with read, write and execute rights. It is tagged with a turf identifier, a thread identifier, or both. Two registers hold the security context of the running code: the current turf and the current thread. A portal switch rewrites the turf register. A thread switch rewrites the thread register. Software loads region entries through a configuration write port.

Each request gives an address, a byte count and the rights it needs. All entries are compared in parallel, and the lowest-numbered entry that covers the whole access, matches the context and holds every needed right grants it. The result comes out one cycle after the request: grant with the index of the winning entry, or fault with the address that failed.

Top module: `turf_guard`

## Requirements
- R1: Reset clears every table entry to invalid and sets both context registers to zero. Until the first configuration write, every request faults. All response outputs are low or zero after reset.
- R2: An entry covers an access only if both the first byte (reqAddr) and the last byte (reqAddr + size - 1) lie inside the entry's inclusive range [lo, hi]. A size of 0 counts as one byte. An access that would wrap past the top of the address space is never covered.
- R3: The rights bits are read = bit 0, write = bit 1 and execute = bit 2, in both reqPerm and cfgPerm. An entry qualifies only if it holds every bit set in reqPerm.
- R4: An entry with only its turf tag enabled matches when its turf equals the current turf register.
- R5: An entry whose turf tag is disabled (the turf is a wildcard) and whose thread tag is enabled matches when its thread equals the current thread register.
- R6: An entry with both tags enabled matches only when the turf and the thread both equal the current registers.
- R7: An entry that is invalid never matches. An entry with neither tag enabled never matches.
- R8: When several entries qualify, the lowest index wins and is reported on rspIdx.
- R9: When no entry qualifies, rspFault is high, rspIdx is 0 and faultAddr equals the request address. On a grant, faultAddr is 0.
- R10: A portal write or a thread write takes effect from the next cycle. A request in the same cycle as the write is checked against the old value.
- R11: The response appears in the cycle after the request. A configuration write changes its entry from the next cycle.
- R12: In a cycle after no request, rspValid, rspGrant and rspFault are low, and rspIdx and faultAddr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWr | input | 1 | Write one table entry |
| cfgIdx | input | IDX_W | Entry index to write |
| cfgValid | input | 1 | Valid flag of the written entry |
| cfgLo | input | ADDR_W | First byte of the range |
| cfgHi | input | ADDR_W | Last byte of the range |
| cfgPerm | input | 3 | Rights of the entry |
| cfgTurfEn | input | 1 | Turf tag enabled |
| cfgTurf | input | TURF_W | Turf tag |
| cfgThreadEn | input | 1 | Thread tag enabled |
| cfgThread | input | THREAD_W | Thread tag |
| portalWr | input | 1 | Load a new current turf |
| portalTurf | input | TURF_W | New turf value |
| threadWr | input | 1 | Load a new current thread |
| threadId | input | THREAD_W | New thread value |
| reqValid | input | 1 | Access request present |
| reqAddr | input | ADDR_W | First byte of the access |
| reqSize | input | SIZE_W | Byte count of the access |
| reqPerm | input | 3 | Rights the access needs |
| rspValid | output | 1 | Response present |
| rspGrant | output | 1 | Access granted |
| rspFault | output | 1 | Access refused |
| rspIdx | output | IDX_W | Index of the granting entry |
| faultAddr | output | ADDR_W | Address of a refused access |

## Verification
The assertions assume that every input holds a known value from the first edge after reset. They also assume that cfgIdx stays below the table depth and that the portal and thread write strobes are low while reset is held. The bench drives every input from a task at the falling edge, clears each strobe after use and draws random entry indices only inside the table. Its random traffic uses a narrow address window and two or three identifiers, so that overlapping entries, tag matches and near-boundary accesses come up often.

// File: rtl/turf_guard_pkg.sv
package turf_guard_pkg;
  localparam int ADDR_W   = 32;
  localparam int TURF_W   = 8;
  localparam int THREAD_W = 8;
  localparam int SIZE_W   = 4;
  localparam int PERM_W   = 3;

  // rights bit positions, shared by requests and entries
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  typedef struct packed {
    logic                valid;
    logic [ADDR_W-1:0]   lo;
    logic [ADDR_W-1:0]   hi;
    logic [PERM_W-1:0]   perm;
    logic                turfEn;
    logic [TURF_W-1:0]   turf;
    logic                threadEn;
    logic [THREAD_W-1:0] thread;
  } region_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tblWr;
    logic lookup;
    logic idle;
  } strobe_t;
endpackage

// File: rtl/turf_guard_ctrl.sv
module turf_guard_ctrl
  import turf_guard_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWr,
  input  logic                portalWr,
  input  logic [TURF_W-1:0]   portalTurf,
  input  logic                threadWr,
  input  logic [THREAD_W-1:0] threadId,
  input  logic                reqValid,
  output strobe_t             strobe,
  output logic [TURF_W-1:0]   curTurf,
  output logic [THREAD_W-1:0] curThread,
  output logic                rspValid
);

  always_comb begin
    strobe.tblWr  = cfgWr;
    strobe.lookup = reqValid;
    strobe.idle   = !reqValid;
  end

  // context registers: a switch is seen by lookups from the next cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curTurf   <= '0;
      curThread <= '0;
    end else begin
      if (portalWr) curTurf   <= portalTurf;
      if (threadWr) curThread <= threadId;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  AST_TURF_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    $past(portalWr) |-> curTurf == $past(portalTurf)); // R10
  AST_THREAD_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    $past(threadWr) |-> curThread == $past(threadId)); // R10
  AST_TURF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(portalWr) |-> $stable(curTurf)); // R10

endmodule

// File: rtl/turf_guard_dp.sv
module turf_guard_dp
  import turf_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  region_t             cfgEntry,
  input  logic [TURF_W-1:0]   curTurf,
  input  logic [THREAD_W-1:0] curThread,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [SIZE_W-1:0]   reqSize,
  input  logic [PERM_W-1:0]   reqPerm,
  output logic                rspGrant,
  output logic                rspFault,
  output logic [IDX_W-1:0]    rspIdx,
  output logic [ADDR_W-1:0]   faultAddr
);

  region_t             tbl [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hitVec;
  logic                hitAny;
  logic [IDX_W-1:0]    hitIdx;
  logic [SIZE_W-1:0]   effSize;
  logic [ADDR_W:0]     accEnd;

  // region table
  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) tbl[g] <= '0;
        else if (strobe.tblWr && (cfgIdx == IDX_W'(g))) tbl[g] <= cfgEntry;
      end
    end
  endgenerate

  // last byte, one bit wider so a wrapping access never fits
  always_comb begin
    effSize = (reqSize == '0) ? SIZE_W'(1) : reqSize;
    accEnd  = {1'b0, reqAddr} + (ADDR_W+1)'(effSize) - (ADDR_W+1)'(1);
  end

  // parallel compare against every entry
  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
      logic inRange;
      logic permOk;
      logic turfHit;
      logic threadHit;
      logic tagOk;
      assign inRange   = (tbl[g].lo <= reqAddr) && (accEnd <= {1'b0, tbl[g].hi});
      assign permOk    = (reqPerm & ~tbl[g].perm) == '0;
      assign turfHit   = tbl[g].turf == curTurf;
      assign threadHit = tbl[g].thread == curThread;
      always_comb begin
        unique case ({tbl[g].turfEn, tbl[g].threadEn})
          2'b11:   tagOk = turfHit && threadHit;
          2'b10:   tagOk = turfHit;
          2'b01:   tagOk = threadHit;
          default: tagOk = 1'b0;
        endcase
      end
      assign hitVec[g] = tbl[g].valid && inRange && permOk && tagOk;
    end
  endgenerate

  // lowest index wins
  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        hitAny = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspGrant  <= 1'b0;
      rspFault  <= 1'b0;
      rspIdx    <= '0;
      faultAddr <= '0;
    end else if (strobe.lookup) begin
      rspGrant  <= hitAny;
      rspFault  <= !hitAny;
      rspIdx    <= hitAny ? hitIdx : '0;
      faultAddr <= hitAny ? '0 : reqAddr;
    end else if (strobe.idle) begin
      rspGrant  <= 1'b0;
      rspFault  <= 1'b0;
      rspIdx    <= '0;
      faultAddr <= '0;
    end
  end

  // checker state: has any entry ever been written since reset
  logic everWritten;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             everWritten <= 1'b0;
    else if (strobe.tblWr) everWritten <= 1'b1;
  end

  AST_EMPTY_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    rspGrant |-> everWritten); // R1
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rspGrant |-> (int'(rspIdx) < NUM_REGIONS)); // R8
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> faultAddr == $past(reqAddr)); // R9
  AST_WRAP_NEVER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookup && accEnd[ADDR_W]) |=> rspFault); // R2

endmodule

// File: rtl/turf_guard.sv
module turf_guard
  import turf_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWr,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic                cfgValid,
  input  logic [ADDR_W-1:0]   cfgLo,
  input  logic [ADDR_W-1:0]   cfgHi,
  input  logic [PERM_W-1:0]   cfgPerm,
  input  logic                cfgTurfEn,
  input  logic [TURF_W-1:0]   cfgTurf,
  input  logic                cfgThreadEn,
  input  logic [THREAD_W-1:0] cfgThread,
  input  logic                portalWr,
  input  logic [TURF_W-1:0]   portalTurf,
  input  logic                threadWr,
  input  logic [THREAD_W-1:0] threadId,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [SIZE_W-1:0]   reqSize,
  input  logic [PERM_W-1:0]   reqPerm,
  output logic                rspValid,
  output logic                rspGrant,
  output logic                rspFault,
  output logic [IDX_W-1:0]    rspIdx,
  output logic [ADDR_W-1:0]   faultAddr
);

  strobe_t             strobe;
  region_t             cfgEntry;
  logic [TURF_W-1:0]   curTurf;
  logic [THREAD_W-1:0] curThread;

  always_comb begin
    cfgEntry.valid    = cfgValid;
    cfgEntry.lo       = cfgLo;
    cfgEntry.hi       = cfgHi;
    cfgEntry.perm     = cfgPerm;
    cfgEntry.turfEn   = cfgTurfEn;
    cfgEntry.turf     = cfgTurf;
    cfgEntry.threadEn = cfgThreadEn;
    cfgEntry.thread   = cfgThread;
  end

  turf_guard_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWr      (cfgWr),
    .portalWr   (portalWr),
    .portalTurf (portalTurf),
    .threadWr   (threadWr),
    .threadId   (threadId),
    .reqValid   (reqValid),
    .strobe     (strobe),
    .curTurf    (curTurf),
    .curThread  (curThread),
    .rspValid   (rspValid)
  );

  turf_guard_dp #(.NUM_REGIONS(NUM_REGIONS)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgIdx    (cfgIdx),
    .cfgEntry  (cfgEntry),
    .curTurf   (curTurf),
    .curThread (curThread),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .reqPerm   (reqPerm),
    .rspGrant  (rspGrant),
    .rspFault  (rspFault),
    .rspIdx    (rspIdx),
    .faultAddr (faultAddr)
  );

  AST_RSP_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot({rspGrant, rspFault})); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspGrant && !rspFault && rspIdx == '0)); // R12

endmodule

// File: tb/test_turf_guard.sv
module test_turf_guard;
  import turf_guard_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int IW = $clog2(NREG);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 0, cfgValid = 0, cfgTurfEn = 0, cfgThreadEn = 0;
  logic [IW-1:0] cfgIdx = '0;
  logic [ADDR_W-1:0] cfgLo = '0, cfgHi = '0;
  logic [PERM_W-1:0] cfgPerm = '0;
  logic [TURF_W-1:0] cfgTurf = '0, portalTurf = '0;
  logic [THREAD_W-1:0] cfgThread = '0, threadId = '0;
  logic portalWr = 0, threadWr = 0, reqValid = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [SIZE_W-1:0] reqSize = '0;
  logic [PERM_W-1:0] reqPerm = '0;
  logic rspValid, rspGrant, rspFault;
  logic [IW-1:0] rspIdx;
  logic [ADDR_W-1:0] faultAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  turf_guard #(.NUM_REGIONS(NREG)) i_turf_guard (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgIdx(cfgIdx), .cfgValid(cfgValid),
    .cfgLo(cfgLo), .cfgHi(cfgHi), .cfgPerm(cfgPerm), .cfgTurfEn(cfgTurfEn),
    .cfgTurf(cfgTurf), .cfgThreadEn(cfgThreadEn), .cfgThread(cfgThread),
    .portalWr(portalWr), .portalTurf(portalTurf), .threadWr(threadWr),
    .threadId(threadId), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqPerm(reqPerm), .rspValid(rspValid),
    .rspGrant(rspGrant), .rspFault(rspFault), .rspIdx(rspIdx),
    .faultAddr(faultAddr)
  );

  // reference model state
  bit          mValid [NREG];
  longint      mLo [NREG], mHi [NREG];
  int          mPerm [NREG];
  bit          mTE [NREG], mHE [NREG];
  int          mTurf [NREG], mThr [NREG];
  int          mCurTurf = 0, mCurThr = 0;
  int          vectors = 0, misses = 0;
  bit          finished = 0;
  bit          eValid = 0, eGrant = 0, eFault = 0;
  int          eIdx = 0;
  longint      eFA = 0;

  function automatic int modelLookup(longint addr, int size, int perm);
    longint last;
    bit tag;
    last = addr + ((size == 0) ? 1 : size) - 1;
    for (int i = 0; i < NREG; i++) begin
      if (mTE[i] && mHE[i])      tag = (mTurf[i] == mCurTurf) && (mThr[i] == mCurThr);
      else if (mTE[i])           tag = (mTurf[i] == mCurTurf);
      else if (mHE[i])           tag = (mThr[i] == mCurThr);
      else                       tag = 0;
      if (mValid[i] && tag && mLo[i] <= addr && last <= mHi[i] &&
          ((perm & ~mPerm[i] & 7) == 0))
        return i;
    end
    return -1;
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  // one clock: predict, update model, clock, compare at falling edge
  task automatic tick(string tag);
    int hit;
    if (reqValid) begin
      hit = modelLookup(longint'(reqAddr), int'(reqSize), int'(reqPerm));
      eValid = 1; eGrant = (hit >= 0); eFault = (hit < 0);
      eIdx = (hit >= 0) ? hit : 0;
      eFA = (hit >= 0) ? 0 : longint'(reqAddr);
    end else begin
      eValid = 0; eGrant = 0; eFault = 0; eIdx = 0; eFA = 0;
    end
    if (cfgWr) begin
      mValid[cfgIdx] = cfgValid; mLo[cfgIdx] = longint'(cfgLo); mHi[cfgIdx] = longint'(cfgHi);
      mPerm[cfgIdx] = int'(cfgPerm); mTE[cfgIdx] = cfgTurfEn; mTurf[cfgIdx] = int'(cfgTurf);
      mHE[cfgIdx] = cfgThreadEn; mThr[cfgIdx] = int'(cfgThread);
    end
    if (portalWr) mCurTurf = int'(portalTurf);
    if (threadWr) mCurThr = int'(threadId);
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (rspValid !== eValid || rspGrant !== eGrant || rspFault !== eFault ||
        int'(rspIdx) != eIdx || longint'(faultAddr) != eFA) begin
      misses++;
      $display("FAIL %s: got v=%0b g=%0b f=%0b idx=%0d fa=%h, expected v=%0b g=%0b f=%0b idx=%0d fa=%h",
               tag, rspValid, rspGrant, rspFault, rspIdx, faultAddr,
               eValid, eGrant, eFault, eIdx, eFA);
    end
  endtask

  task automatic cfg(int idx, bit v, longint lo, longint hi, int perm,
                     bit te, int t, bit he, int h);
    cfgWr = 1; cfgIdx = IW'(idx); cfgValid = v; cfgLo = ADDR_W'(lo); cfgHi = ADDR_W'(hi);
    cfgPerm = PERM_W'(perm); cfgTurfEn = te; cfgTurf = TURF_W'(t);
    cfgThreadEn = he; cfgThread = THREAD_W'(h);
    tick("R11 R12");
    cfgWr = 0;
  endtask

  task automatic access(longint addr, int size, int perm, string tag);
    reqValid = 1; reqAddr = ADDR_W'(addr); reqSize = SIZE_W'(size); reqPerm = PERM_W'(perm);
    tick(tag);
    reqValid = 0;
  endtask

  task automatic setTurf(int t);
    portalWr = 1; portalTurf = TURF_W'(t); tick("R10"); portalWr = 0;
  endtask

  task automatic setThread(int h);
    threadWr = 1; threadId = THREAD_W'(h); tick("R10"); threadWr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: got timeout, expected completion");
      report();
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin
      mValid[i] = 0; mLo[i] = 0; mHi[i] = 0; mPerm[i] = 0;
      mTE[i] = 0; mHE[i] = 0; mTurf[i] = 0; mThr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    tick("R1");                               // quiet after reset
    access(32'h0000_1000, 1, 1, "R1");        // empty table faults
    access(32'h0000_0000, 0, 0, "R1");

    // R4 / R10: turf-only entry, turf changes from next cycle
    cfg(0, 1, 32'h1000, 32'h1FFF, 3, 1, 5, 0, 0);
    portalWr = 1; portalTurf = 5;
    access(32'h1000, 4, 1, "R10");            // still old turf 0 -> fault
    portalWr = 0;
    access(32'h1000, 4, 1, "R4");             // now granted, idx 0
    tick("R12");

    // R2: range edges
    access(32'h1FFC, 4, 1, "R2");
    access(32'h1FFD, 4, 1, "R2");
    access(32'h0FFF, 1, 1, "R2");
    access(32'h1FFF, 0, 2, "R2");

    // R3: rights
    access(32'h1100, 1, 4, "R3");
    access(32'h1100, 2, 3, "R3");
    access(32'h1100, 2, 7, "R3");

    // R5: wildcard turf, thread match
    cfg(1, 1, 32'h2000, 32'h2FFF, 1, 0, 0, 1, 7);
    setThread(7);
    access(32'h2000, 8, 1, "R5");
    setThread(6);
    access(32'h2000, 8, 1, "R5");

    // R6: both tags
    cfg(2, 1, 32'h3000, 32'h30FF, 7, 1, 5, 1, 9);
    setThread(9);
    access(32'h3010, 4, 4, "R6");
    setTurf(6);
    access(32'h3010, 4, 4, "R6");

    // R7: untagged entry never matches, invalid entry never matches
    cfg(3, 1, 32'h3000, 32'h30FF, 7, 0, 0, 0, 0);
    access(32'h3010, 4, 1, "R7");
    setTurf(5);
    cfg(0, 0, 32'h1000, 32'h1FFF, 3, 1, 5, 0, 0);
    access(32'h1000, 4, 1, "R7");

    // R8: overlap, lowest qualifying index
    cfg(4, 1, 32'h2000, 32'h2FFF, 7, 1, 5, 0, 0);
    setThread(7);
    access(32'h2040, 4, 1, "R8");             // idx 1
    access(32'h2040, 4, 2, "R8");             // idx 1 lacks write -> idx 4

    // R2 / R9: top of address space
    cfg(5, 1, 32'hFFFF_FF00, 32'hFFFF_FFFF, 1, 1, 5, 0, 0);
    access(32'hFFFF_FFFE, 4, 1, "R9");
    access(32'hFFFF_FFFE, 2, 1, "R2");

    // random traffic, model compared every clock
    for (int n = 0; n < 4000; n++) begin
      cfgWr = ($urandom_range(0, 7) == 0);
      cfgIdx = IW'($urandom_range(0, NREG-1));
      cfgValid = ($urandom_range(0, 5) != 0);
      cfgLo = ADDR_W'($urandom_range(0, 1023));
      cfgHi = cfgLo + ADDR_W'($urandom_range(0, 511));
      cfgPerm = PERM_W'($urandom_range(0, 7));
      cfgTurfEn = $urandom_range(0, 1); cfgTurf = TURF_W'($urandom_range(0, 2));
      cfgThreadEn = $urandom_range(0, 1); cfgThread = THREAD_W'($urandom_range(0, 2));
      portalWr = ($urandom_range(0, 9) == 0); portalTurf = TURF_W'($urandom_range(0, 2));
      threadWr = ($urandom_range(0, 9) == 0); threadId = THREAD_W'($urandom_range(0, 2));
      reqValid = ($urandom_range(0, 3) != 0);
      reqAddr = ADDR_W'($urandom_range(0, 1535));
      reqSize = SIZE_W'($urandom_range(0, 15));
      reqPerm = PERM_W'($urandom_range(0, 7));
      tick("R8 R9 random");
    end
    cfgWr = 0; portalWr = 0; threadWr = 0; reqValid = 0;
    tick("R12");
    finished = 1;
    report();
  end

endmodule